// File: doc/BRIEF.md
# Six-Step Spindle Commutation Sequencer

This block chooses which of the three spindle motor phases is pulled high, which is pulled low and which is left floating. There are six commutation steps. In sensor mode the step comes straight from three Hall comparator bits. In sensorless mode the motor is first stepped by an external start clock. Once the motor spins, the block follows the back-EMF zero crossings seen on the floating phase.

Back-EMF sensing is blanked in three cases:
- while the start clock is high;
- until the start clock has forced a set number of steps;
- during a fixed window after each accepted crossing. This window is also the speed pulse.

After an accepted crossing, the next step is applied once a programmable delay has run out. A chip-enable input and a brake request, with a brake-style select, take priority over the normal drive pattern.

Top module: `bldc_commutator`

## Requirements
- R1: After reset in sensorless mode the block sits at step 0: U high-side on (hs_en=001), V low-side on (ls_en=010), W floating (hiz=100), and speed_out is low.
- R2: While chip_en is low, every phase floats (hiz=111, hs_en=ls_en=000) in the same cycle, whatever the other inputs are.
- R3: While chip_en is high, brake_req is high and brake_sel is low (short brake), all low-side switches are on (ls_en=111, hs_en=000, hiz=000).
- R4: While chip_en, brake_req and brake_sel are high (reverse brake), the outputs show the pattern of the step three places ahead of the current one (the opposite torque direction).
- R5: Each step drives exactly one phase high, one low and one floating. Phase bit 0 is U, bit 1 is V and bit 2 is W. As (high, low, float) the steps are: 0=(U,V,W), 1=(U,W,V), 2=(V,W,U), 3=(V,U,W), 4=(W,U,V), 5=(W,V,U).
- R6: In sensor mode (sensorless low) the step follows hall_in = {W,V,U}: 101→0, 001→1, 011→2, 010→3, 110→4, 100→5. The new pattern appears within four clock edges.
- R7: In sensor mode the Hall codes 000 and 111 float every phase.
- R8: In sensor mode speed_out follows the synchronized U Hall bit. With 12 poles this gives 6 cycles per rotation.
- R9: In sensorless mode each rising edge of start_clk advances the step by one, wrapping from 5 to 0.
- R10: In sensorless mode zero crossings are ignored until FORCE_STEPS (default 6) start-clock steps have been taken since reset or since sensor mode was last selected.
- R11: Zero crossings are ignored while start_clk is high.
- R12: Only the floating phase's zc_in bit is watched. It must fall in even steps and rise in odd steps. A transition the other way, or on a driven phase, has no effect.
- R13: An accepted crossing raises speed_out on the third clock edge after the input changes. It stays high for MASK_CYC (default 64) cycles, and crossings during that time are ignored.
- R14: The step advances delay_cfg+1 clock edges after the crossing is accepted, so on edge delay_cfg+4 after the input change. delay_cfg is captured while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; delay_cfg is captured while it is low |
| chip_en | input | 1 | Low floats every phase |
| sensorless | input | 1 | High: back-EMF commutation; low: Hall commutation |
| brake_req | input | 1 | Requests braking |
| brake_sel | input | 1 | Brake style: low short, high reverse |
| start_clk | input | 1 | Asynchronous start-up stepping clock |
| hall_in | input | 3 | Asynchronous Hall comparator bits {W,V,U} |
| zc_in | input | 3 | Asynchronous back-EMF comparator bits {W,V,U} |
| delay_cfg | input | DLY_W | Post-crossing delay in clocks |
| hs_en | output | 3 | High-side enable per phase {W,V,U} |
| ls_en | output | 3 | Low-side enable per phase {W,V,U} |
| hiz | output | 3 | Floating flag per phase {W,V,U} |
| speed_out | output | 1 | Speed pulse |

## Verification
The bench sends crossings before the forced steps are complete and while the start clock is high. A design with weak blanking would raise the speed pulse there and jump a step. It also toggles the floating bit in the wrong direction and toggles a driven phase's bit. A design watching the wrong bit or the wrong polarity would commutate on noise. It measures the exact edges at which the pulse rises and falls and at which the delayed step lands, which exposes an off-by-one in the delay or window counters. Finally it sends a correct-direction crossing inside the blanking window and checks that the step does not move.

// File: rtl/bldc_pkg.sv
`timescale 1ns/1ps
package bldc_pkg;

   typedef logic [2:0] step_t;
   typedef logic [1:0] phase_t;

   localparam int NUM_STEPS  = 6;
   localparam int NUM_PHASES = 3;

   function automatic step_t step_next(input step_t s);
      return (s == step_t'(NUM_STEPS - 1)) ? step_t'(0) : s + step_t'(1);
   endfunction

   function automatic step_t step_opposite(input step_t s);
      return (s >= step_t'(3)) ? s - step_t'(3) : s + step_t'(3);
   endfunction

   function automatic phase_t phase_high(input step_t s);
      return phase_t'(s >> 1);
   endfunction

   function automatic phase_t phase_low(input step_t s);
      phase_t p;
      case (s)
         3'd0, 3'd5: p = 2'd1;
         3'd1, 3'd2: p = 2'd2;
         default:    p = 2'd0;
      endcase
      return p;
   endfunction

   function automatic phase_t phase_float(input step_t s);
      phase_t p;
      case (s)
         3'd0, 3'd3: p = 2'd2;
         3'd1, 3'd4: p = 2'd1;
         default:    p = 2'd0;
      endcase
      return p;
   endfunction

   // returns {valid, step}
   function automatic logic [3:0] hall_decode(input logic [2:0] h);
      logic [3:0] r;
      case (h)
         3'b101:  r = {1'b1, 3'd0};
         3'b001:  r = {1'b1, 3'd1};
         3'b011:  r = {1'b1, 3'd2};
         3'b010:  r = {1'b1, 3'd3};
         3'b110:  r = {1'b1, 3'd4};
         3'b100:  r = {1'b1, 3'd5};
         default: r = {1'b0, 3'd0};
      endcase
      return r;
   endfunction

endpackage

// File: rtl/bldc_sync.sv
`timescale 1ns/1ps
module bldc_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) begin
            chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/bldc_blank_timer.sv
`timescale 1ns/1ps
module bldc_blank_timer #(
   parameter int CYC = 64,
   localparam int CW = $clog2(CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic busy
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= CW'(CYC);
      end else if (cnt != '0) begin
         cnt <= cnt - CW'(1);
      end
   end

   assign busy = (cnt != '0);
endmodule

// File: rtl/bldc_step_ctrl.sv
`timescale 1ns/1ps
module bldc_step_ctrl
   import bldc_pkg::*;
#(
   parameter int DLY_W       = 8,
   parameter int MASK_CYC    = 64,
   parameter int FORCE_STEPS = 6,
   localparam int FC_W = $clog2(FORCE_STEPS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sensorless,
   input  logic             start_s,
   input  logic [2:0]       hall_s,
   input  logic [2:0]       zc_s,
   input  logic [DLY_W-1:0] dly,
   output step_t            step,
   output logic             step_ok,
   output logic             speed
);
   step_t            step_q;
   logic             hall_bad_q;
   logic             start_q;
   logic [2:0]       zc_q;
   logic [FC_W-1:0]  force_cnt;
   logic             pend_q;
   logic [DLY_W-1:0] dly_cnt;
   logic             mask_busy;

   logic [3:0] hall_dec;
   logic       start_rise;
   phase_t     fl_ph;
   logic       want_lvl;
   logic       zc_edge;
   logic       armed;
   logic       accept;

   assign hall_dec   = hall_decode(hall_s);
   assign start_rise = start_s & ~start_q;
   assign fl_ph      = phase_float(step_q);
   assign want_lvl   = step_q[0];
   assign zc_edge    = (zc_s[fl_ph] != zc_q[fl_ph]) && (zc_s[fl_ph] == want_lvl);
   assign armed      = sensorless && !start_s && !mask_busy && !pend_q &&
                       (force_cnt == FC_W'(FORCE_STEPS));
   assign accept     = armed && zc_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         zc_q    <= '0;
      end else begin
         start_q <= start_s;
         zc_q    <= zc_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q     <= '0;
         hall_bad_q <= 1'b0;
         force_cnt  <= '0;
         pend_q     <= 1'b0;
         dly_cnt    <= '0;
      end else if (!sensorless) begin
         step_q     <= hall_dec[2:0];
         hall_bad_q <= ~hall_dec[3];
         force_cnt  <= '0;
         pend_q     <= 1'b0;
      end else begin
         hall_bad_q <= 1'b0;
         if (start_rise) begin
            step_q <= step_next(step_q);
            pend_q <= 1'b0;
            if (force_cnt != FC_W'(FORCE_STEPS)) begin
               force_cnt <= force_cnt + FC_W'(1);
            end
         end else if (pend_q) begin
            if (dly_cnt == '0) begin
               step_q <= step_next(step_q);
               pend_q <= 1'b0;
            end else begin
               dly_cnt <= dly_cnt - DLY_W'(1);
            end
         end else if (accept) begin
            pend_q  <= 1'b1;
            dly_cnt <= dly;
         end
      end
   end

   bldc_blank_timer #(.CYC(MASK_CYC)) u_blank (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .busy  (mask_busy)
   );

   assign step    = step_q;
   assign step_ok = ~hall_bad_q;
   assign speed   = sensorless ? mask_busy : hall_s[0];
endmodule

// File: rtl/bldc_phase_drive.sv
`timescale 1ns/1ps
module bldc_phase_drive
   import bldc_pkg::*;
(
   input  step_t      step,
   input  logic       step_ok,
   input  logic       chip_en,
   input  logic       brake_req,
   input  logic       brake_sel,
   output logic [2:0] hs_en,
   output logic [2:0] ls_en,
   output logic [2:0] hiz
);
   step_t  eff;
   phase_t hi_ph;
   phase_t lo_ph;
   logic   off_all;
   logic   short_brk;

   assign eff       = (brake_req && brake_sel) ? step_opposite(step) : step;
   assign hi_ph     = phase_high(eff);
   assign lo_ph     = phase_low(eff);
   assign off_all   = !chip_en || (!brake_req && !step_ok);
   assign short_brk = brake_req && !brake_sel;

   for (genvar p = 0; p < NUM_PHASES; p++) begin : g_ph
      logic hi_sel;
      logic lo_sel;
      assign hi_sel   = (hi_ph == phase_t'(p));
      assign lo_sel   = (lo_ph == phase_t'(p));
      assign hs_en[p] = !off_all && !short_brk && hi_sel;
      assign ls_en[p] = !off_all && (short_brk || lo_sel);
      assign hiz[p]   = off_all || (!short_brk && !hi_sel && !lo_sel);
   end
endmodule

// File: rtl/bldc_commutator.sv
`timescale 1ns/1ps
module bldc_commutator
   import bldc_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DLY_W       = 8,
   parameter int MASK_CYC    = 64,
   parameter int FORCE_STEPS = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chip_en,
   input  logic             sensorless,
   input  logic             brake_req,
   input  logic             brake_sel,
   input  logic             start_clk,
   input  logic [2:0]       hall_in,
   input  logic [2:0]       zc_in,
   input  logic [DLY_W-1:0] delay_cfg,
   output logic [2:0]       hs_en,
   output logic [2:0]       ls_en,
   output logic [2:0]       hiz,
   output logic             speed_out
);
   localparam int SYNC_W = 1 + 3 + 3;

   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (MASK_CYC < 1) begin : g_chk_mask
      $error("MASK_CYC must be positive");
   end
   if (FORCE_STEPS < 1) begin : g_chk_force
      $error("FORCE_STEPS must be positive");
   end
   if (DLY_W < 1) begin : g_chk_dly
      $error("DLY_W must be positive");
   end

   logic [SYNC_W-1:0] raw_in;
   logic [SYNC_W-1:0] syn_in;
   logic [DLY_W-1:0]  dly_q;
   step_t             step;
   logic              step_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dly_q <= delay_cfg;
      end
   end

   assign raw_in = {start_clk, hall_in, zc_in};

   bldc_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn_in)
   );

   bldc_step_ctrl #(
      .DLY_W       (DLY_W),
      .MASK_CYC    (MASK_CYC),
      .FORCE_STEPS (FORCE_STEPS)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .sensorless (sensorless),
      .start_s    (syn_in[6]),
      .hall_s     (syn_in[5:3]),
      .zc_s       (syn_in[2:0]),
      .dly        (dly_q),
      .step       (step),
      .step_ok    (step_ok),
      .speed      (speed_out)
   );

   bldc_phase_drive u_drive (
      .step      (step),
      .step_ok   (step_ok),
      .chip_en   (chip_en),
      .brake_req (brake_req),
      .brake_sel (brake_sel),
      .hs_en     (hs_en),
      .ls_en     (ls_en),
      .hiz       (hiz)
   );
endmodule

// File: rtl/bldc_commutator_chk.sv
`timescale 1ns/1ps
module bldc_commutator_chk #(
   parameter int MASK_CYC = 64,
   localparam int RW = $clog2(MASK_CYC + 2)
) (
   input logic       clk,
   input logic       rst_n,
   input logic       chip_en,
   input logic       sensorless,
   input logic       brake_req,
   input logic       brake_sel,
   input logic [2:0] hs_en,
   input logic [2:0] ls_en,
   input logic [2:0] hiz,
   input logic       speed_out
);
   logic [RW-1:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_len <= '0;
      end else if (sensorless && speed_out) begin
         if (run_len != {RW{1'b1}}) run_len <= run_len + RW'(1);
      end else begin
         run_len <= '0;
      end
   end

   a_r2_disabled_floats: assert property (@(posedge clk) disable iff (!rst_n)
      !chip_en |-> (hiz == 3'b111 && hs_en == 3'b000 && ls_en == 3'b000));

   a_r3_short_brake: assert property (@(posedge clk) disable iff (!rst_n)
      (chip_en && brake_req && !brake_sel) |-> (ls_en == 3'b111 && hs_en == 3'b000));

   a_r4_reverse_one_each: assert property (@(posedge clk) disable iff (!rst_n)
      (chip_en && brake_req && brake_sel) |->
         ($countones(hs_en) == 1 && $countones(ls_en) == 1 && $countones(hiz) == 1));

   a_r5_sensorless_one_each: assert property (@(posedge clk) disable iff (!rst_n)
      (chip_en && !brake_req && sensorless) |->
         ($countones(hs_en) == 1 && $countones(ls_en) == 1 && $countones(hiz) == 1));

   a_r5_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_en & ls_en) == 3'b000);

   a_r13_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
      sensorless |-> (run_len <= RW'(MASK_CYC)));
endmodule

bind bldc_commutator bldc_commutator_chk #(.MASK_CYC(MASK_CYC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .chip_en    (chip_en),
   .sensorless (sensorless),
   .brake_req  (brake_req),
   .brake_sel  (brake_sel),
   .hs_en      (hs_en),
   .ls_en      (ls_en),
   .hiz        (hiz),
   .speed_out  (speed_out)
);

// File: tb/bldc_commutator_test.sv
`timescale 1ns/1ps
module bldc_commutator_test;
   localparam int DLY = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       chip_en = 1'b1;
   logic       sensorless = 1'b1;
   logic       brake_req = 1'b0;
   logic       brake_sel = 1'b0;
   logic       start_clk = 1'b0;
   logic [2:0] hall_in = 3'b000;
   logic [2:0] zc_in = 3'b000;
   logic [7:0] delay_cfg = 8'(DLY);
   logic [2:0] hs_en;
   logic [2:0] ls_en;
   logic [2:0] hiz;
   logic       speed_out;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   bldc_commutator uut (
      .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .sensorless(sensorless),
      .brake_req(brake_req), .brake_sel(brake_sel), .start_clk(start_clk),
      .hall_in(hall_in), .zc_in(zc_in), .delay_cfg(delay_cfg),
      .hs_en(hs_en), .ls_en(ls_en), .hiz(hiz), .speed_out(speed_out)
   );

   // {hs, ls, hiz} per step
   localparam logic [8:0] ST0 = {3'b001, 3'b010, 3'b100};
   localparam logic [8:0] ST1 = {3'b001, 3'b100, 3'b010};
   localparam logic [8:0] ST2 = {3'b010, 3'b100, 3'b001};
   localparam logic [8:0] ST3 = {3'b010, 3'b001, 3'b100};
   localparam logic [8:0] ST4 = {3'b100, 3'b001, 3'b010};
   localparam logic [8:0] ST5 = {3'b100, 3'b010, 3'b001};
   localparam logic [8:0] FLT = {3'b000, 3'b000, 3'b111};

   // {hall[11:9], hs[8:6], ls[5:3], hiz[2:0]}
   localparam logic [11:0] HALL_VEC [8] = '{
      {3'b101, ST0}, {3'b001, ST1}, {3'b011, ST2}, {3'b010, ST3},
      {3'b110, ST4}, {3'b100, ST5}, {3'b000, FLT}, {3'b111, FLT}
   };

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   function automatic logic [8:0] drv();
      return {hs_en, ls_en, hiz};
   endfunction

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      tick(4);
      rst_n = 1'b1;
      tick(1);
      chk("R1 reset step 0", drv(), ST0);
      chk("R1 reset speed", {8'b0, speed_out}, 9'd0);

      // R10: crossing on W before forced steps are done
      zc_in = 3'b100; tick(6);
      zc_in = 3'b000; tick(6);
      chk("R10 early crossing speed", {8'b0, speed_out}, 9'd0);
      chk("R10 early crossing step", drv(), ST0);

      // R9: six start-clock steps
      for (int i = 0; i < 6; i++) begin
         start_clk = 1'b1; tick(4);
         if (i == 0) chk("R9 first forced step", drv(), ST1);
         if (i == 2) chk("R9 third forced step", drv(), ST3);
         start_clk = 1'b0; tick(4);
      end
      chk("R9 wrap to step 0", drv(), ST0);

      // R11: crossing while start clock high
      start_clk = 1'b1; tick(4);
      chk("R9 seventh step", drv(), ST1);
      zc_in = 3'b010; tick(8);
      chk("R11 masked speed", {8'b0, speed_out}, 9'd0);
      chk("R11 masked step", drv(), ST1);
      start_clk = 1'b0; tick(4);
      chk("R11 after release", drv(), ST1);

      // R12: wrong direction and driven-phase edges
      zc_in = 3'b000; tick(8);
      chk("R12 wrong direction speed", {8'b0, speed_out}, 9'd0);
      chk("R12 wrong direction step", drv(), ST1);
      zc_in = 3'b001; tick(8);
      zc_in = 3'b000; tick(8);
      chk("R12 driven phase speed", {8'b0, speed_out}, 9'd0);
      chk("R12 driven phase step", drv(), ST1);

      // R13 / R14: accepted rising crossing on V
      zc_in = 3'b010;
      for (int e = 1; e <= 70; e++) begin
         tick(1);
         if (e == 2)  chk("R13 speed before third edge", {8'b0, speed_out}, 9'd0);
         if (e == 3)  chk("R13 speed at third edge", {8'b0, speed_out}, 9'd1);
         if (e == 8)  chk("R14 step held during delay", drv(), ST1);
         if (e == 9)  chk("R14 step after delay", drv(), ST2);
         if (e == 10) zc_in = 3'b011;
         if (e == 20) zc_in = 3'b010;
         if (e == 66) chk("R13 speed last high cycle", {8'b0, speed_out}, 9'd1);
         if (e == 67) chk("R13 speed falls", {8'b0, speed_out}, 9'd0);
         if (e == 70) chk("R13 masked crossing ignored", drv(), ST2);
      end
      tick(10);
      chk("R13 no late commutation", drv(), ST2);
      chk("R13 speed stays low", {8'b0, speed_out}, 9'd0);

      // R6 / R7 / R8: Hall table
      sensorless = 1'b0;
      for (int i = 0; i < 8; i++) begin
         hall_in = HALL_VEC[i][11:9];
         tick(4);
         if (i < 6) chk("R6 hall step", drv(), HALL_VEC[i][8:0]);
         else       chk("R7 invalid hall", drv(), HALL_VEC[i][8:0]);
         chk("R8 hall speed", {8'b0, speed_out}, {8'b0, HALL_VEC[i][9]});
      end

      // R3 / R4 / R2 with step 2
      hall_in = 3'b011; tick(4);
      chk("R5 step 2 pattern", drv(), ST2);
      brake_req = 1'b1; brake_sel = 1'b0; tick(1);
      chk("R3 short brake", drv(), {3'b000, 3'b111, 3'b000});
      brake_sel = 1'b1; tick(1);
      chk("R4 reverse brake", drv(), ST5);
      chip_en = 1'b0; tick(1);
      chk("R2 disabled during brake", drv(), FLT);
      brake_req = 1'b0; tick(1);
      chk("R2 disabled", drv(), FLT);
      chip_en = 1'b1; tick(1);
      chk("R2 re-enabled", drv(), ST2);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule